// File: doc/BRIEF.md
# Register-Triggered Multiply/Divide Unit

This block is a small arithmetic helper that sits behind a register bus. A host loads operand bytes by address. Writing the second operand of a pair starts the operation for that pair. The multiply path forms an 8-bit by 8-bit unsigned product in one cycle. The divide path divides a 16-bit unsigned dividend by an 8-bit unsigned divisor. It uses an iterative restoring divider that produces one quotient bit per cycle.

There are two result registers. One holds the quotient. The other is shared: a multiply writes the product into it, and a divide writes the remainder into it. The host reads both result registers one byte at a time through a combinational read port.

Writes arrive on a valid/ready handshake. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While a division is running, `wr_ready` is low. During that time every write, trigger or not, is held off by the handshake. The host must keep `wr_valid`, `wr_addr` and `wr_data` steady until the write is taken. No write is ever dropped.

Top module: `mdu_top`

## Requirements
- R1: After reset, all four result bytes read 0x00, `busy` is low and `wr_ready` is high.
- R2: An accepted write to address 1 (multiplier) puts the 16-bit product of the stored multiplicand and the written byte into the shared result register. The product is readable from the first cycle after the accepting edge.
- R3: A multiply leaves the quotient register unchanged.
- R4: Writes to address 2 (dividend low byte) and address 3 (dividend high byte) only store the byte. They start nothing, leave both result registers unchanged and leave `busy` low.
- R5: An accepted write of a nonzero byte to address 4 (divisor) starts a division. When `busy` falls, the quotient register holds dividend / divisor and the shared register holds dividend mod divisor, zero-extended to 16 bits.
- R6: An accepted divisor write of 0x00 sets the quotient to 0xFFFF and copies the dividend unchanged into the shared register. Both are readable in the next cycle, and `busy` stays low.
- R7: After a nonzero divisor write, `busy` is high for exactly 17 cycles, starting in the cycle after the accepting edge. `wr_ready` is low in every one of those cycles.
- R8: While `busy` is high, reads return the result values from before the division started.
- R9: A divide leaves the stored multiplicand unchanged.
- R10: Out of reset, the multiplicand is 0xFF and the dividend is 0xFFFF, so operations can run without loading those operands first.
- R11: The read address selects the byte: 0 = quotient bits 7:0, 1 = quotient bits 15:8, 2 = shared result bits 7:0, 3 = shared result bits 15:8.
- R12: Writes to addresses 5 to 7 are accepted and change no operand and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be taken this cycle (low while busy) |
| wr_addr | input | 3 | Operand address: 0 multiplicand, 1 multiplier, 2 dividend low, 3 dividend high, 4 divisor |
| wr_data | input | 8 | Operand byte |
| rd_addr | input | 2 | Result byte select |
| rd_data | output | 8 | Selected result byte (combinational) |
| busy | output | 1 | Division in progress |

## Verification
The hardest window to reach from the ports is the set of busy cycles. Inside it, the old results must stay visible and writes must be refused. The capture edge at its end must not coincide with any accepted write. The stimulus issues a divisor write and then samples `busy`, `wr_ready` and the read port in every following cycle until `busy` falls. The zero-divisor path and a dividend smaller than the divisor are placed in the vector table, so both bypass and iteration edge cases appear among ordinary operations.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    WA_MCAND   = 3'd0,
    WA_MPLIER  = 3'd1,
    WA_DVD_LO  = 3'd2,
    WA_DVD_HI  = 3'd3,
    WA_DIVISOR = 3'd4
  } waddr_e;

  typedef enum logic [1:0] {
    RA_QUO_LO = 2'd0,
    RA_QUO_HI = 2'd1,
    RA_RES_LO = 2'd2,
    RA_RES_HI = 2'd3
  } raddr_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic [2*OPW-1:0] p
);
  always_comb p = a * b;
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2*OPW-1:0] dividend,
  input  logic [OPW-1:0]   divisor,
  output logic             busy,
  output logic             done,
  output logic [2*OPW-1:0] quo,
  output logic [OPW-1:0]   rem
);
  localparam int DW = 2 * OPW;
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0]  cnt;
  logic [DW-1:0]  q_sh;
  logic [OPW-1:0] r_acc;
  logic [OPW-1:0] dvs;
  logic           done_q;
  logic [OPW:0]   trial;
  logic           ge;
  logic [OPW-1:0] diff;
  logic [OPW-1:0] r_next;

  always_comb begin
    trial  = {r_acc, q_sh[DW-1]};
    ge     = trial >= {1'b0, dvs};
    diff   = trial[OPW-1:0] - dvs;
    r_next = ge ? diff : trial[OPW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      q_sh   <= '0;
      r_acc  <= '0;
      dvs    <= '1;
      done_q <= 1'b0;
    end else if (start) begin
      q_sh   <= dividend;
      r_acc  <= '0;
      dvs    <= divisor;
      cnt    <= CW'(DW);
      done_q <= 1'b0;
    end else if (cnt != '0) begin
      q_sh   <= {q_sh[DW-2:0], ge};
      r_acc  <= r_next;
      cnt    <= cnt - 1'b1;
      done_q <= (cnt == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy = (cnt != '0) || done_q;
  assign done = done_q;
  assign quo  = q_sh;
  assign rem  = r_acc;
endmodule

// File: rtl/mdu_rdmux.sv
module mdu_rdmux
  import mdu_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [1:0]       sel,
  input  logic [2*OPW-1:0] quo,
  input  logic [2*OPW-1:0] res,
  output logic [OPW-1:0]   data
);
  always_comb begin
    case (raddr_e'(sel))
      RA_QUO_LO: data = quo[OPW-1:0];
      RA_QUO_HI: data = quo[2*OPW-1:OPW];
      RA_RES_LO: data = res[OPW-1:0];
      default:   data = res[2*OPW-1:OPW];
    endcase
  end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [2:0]     wr_addr,
  input  logic [OPW-1:0] wr_data,
  input  logic [1:0]     rd_addr,
  output logic [OPW-1:0] rd_data,
  output logic           busy
);
  localparam int DW = 2 * OPW;

  logic [OPW-1:0] mcand_q;
  logic [DW-1:0]  dvd_q;
  logic [DW-1:0]  quot_q;
  logic [DW-1:0]  res_q;
  logic [DW-1:0]  prod;
  logic           acc;
  logic           div_start;
  logic           div_busy;
  logic           div_done;
  logic [DW-1:0]  div_quo;
  logic [OPW-1:0] div_rem;

  assign acc       = wr_valid && wr_ready;
  assign div_start = acc && (waddr_e'(wr_addr) == WA_DIVISOR) && (wr_data != '0);
  assign wr_ready  = !div_busy;
  assign busy      = div_busy;

  mdu_mul #(.OPW(OPW)) u_mul (.a(mcand_q), .b(wr_data), .p(prod));

  mdu_div #(.OPW(OPW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(dvd_q), .divisor(wr_data),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  mdu_rdmux #(.OPW(OPW)) u_rd (.sel(rd_addr), .quo(quot_q), .res(res_q), .data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '1;
      dvd_q   <= '1;
      quot_q  <= '0;
      res_q   <= '0;
    end else if (div_done) begin
      quot_q <= div_quo;
      res_q  <= {{OPW{1'b0}}, div_rem};
    end else if (acc) begin
      case (waddr_e'(wr_addr))
        WA_MCAND:  mcand_q <= wr_data;
        WA_MPLIER: res_q <= prod;
        WA_DVD_LO: dvd_q[OPW-1:0] <= wr_data;
        WA_DVD_HI: dvd_q[DW-1:OPW] <= wr_data;
        WA_DIVISOR: begin
          if (wr_data == '0) begin
            quot_q <= '1;
            res_q  <= dvd_q;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int OPW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [2:0]       wr_addr,
  input logic [OPW-1:0]   wr_data,
  input logic             busy,
  input logic [2*OPW-1:0] quot_q,
  input logic [2*OPW-1:0] res_q
);
  logic acc;
  assign acc = wr_valid && wr_ready;

  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  a_r8_quot_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(quot_q)));

  a_r8_res_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(res_q)));

  a_r3_mul_keeps_quot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 3'd1) |=> $stable(quot_q));

  a_r4_dvd_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (wr_addr == 3'd2 || wr_addr == 3'd3)) |=> (!busy && $stable(quot_q) && $stable(res_q)));

  a_r6_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 3'd4 && wr_data == '0) |=> (quot_q == '1 && !busy));

  a_r7_div_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 3'd4 && wr_data != '0) |=> busy);
endmodule

bind mdu_top mdu_chk #(.OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
  .quot_q(quot_q), .res_q(res_q)
);

// File: tb/sim_mdu_top.sv
`timescale 1ns/1ps
module sim_mdu_top;
  localparam int DIV_LAT = 17;
  localparam int NV = 8;
  // {multiplicand, multiplier, dividend, divisor}
  localparam logic [39:0] VEC [NV] = '{
    {8'h12, 8'h34, 16'h1234, 8'h07},
    {8'hFF, 8'hFF, 16'hFFFF, 8'h01},
    {8'h00, 8'h9A, 16'h0000, 8'h05},
    {8'h80, 8'h02, 16'h8000, 8'hFF},
    {8'h0F, 8'hF0, 16'h00FE, 8'hFF},
    {8'h55, 8'hAA, 16'hABCD, 8'h00},
    {8'h01, 8'h01, 16'h0003, 8'h10},
    {8'hC3, 8'h3C, 16'hFFFE, 8'h02}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy;

  int tests = 0;
  int fails = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  mdu_top u0 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
              .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
              .rd_data(rd_data), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd8(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic rd16(input bit res, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(res ? 2'd2 : 2'd0, lo);
    rd8(res ? 2'd3 : 2'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    logic [15:0] q, r, exp_q, exp_r;
    logic [7:0] b;
    int n;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      rd8(2'(k), b);
      chk("R1 reset result byte", {24'h0, b}, 32'h0);
    end
    chk("R1 busy low", {31'h0, busy}, 32'h0);
    chk("R1 ready high", {31'h0, wr_ready}, 32'h1);

    // R10 default multiplicand 0xFF
    wr(3'd1, 8'h02);
    rd16(1, r);
    chk("R10 default multiplicand", {16'h0, r}, 32'h01FE);
    // R10 default dividend 0xFFFF
    wr(3'd4, 8'h10);
    while (busy) @(negedge clk);
    rd16(0, q); rd16(1, r);
    chk("R10 default dividend quotient", {16'h0, q}, 32'h0FFF);
    chk("R10 default dividend remainder", {16'h0, r}, 32'h000F);
    // R11 byte map
    rd8(2'd0, b); chk("R11 quotient low", {24'h0, b}, 32'hFF);
    rd8(2'd1, b); chk("R11 quotient high", {24'h0, b}, 32'h0F);
    rd8(2'd2, b); chk("R11 result low", {24'h0, b}, 32'h0F);
    rd8(2'd3, b); chk("R11 result high", {24'h0, b}, 32'h00);
    // R12 unused addresses
    wr(3'd5, 8'h77); wr(3'd6, 8'h11); wr(3'd7, 8'h22);
    rd16(0, q); rd16(1, r);
    chk("R12 quotient untouched", {16'h0, q}, 32'h0FFF);
    chk("R12 result untouched", {16'h0, r}, 32'h000F);
    wr(3'd1, 8'h01);
    rd16(1, r);
    chk("R12 multiplicand untouched", {16'h0, r}, 32'h00FF);
    exp_q = 16'h0FFF;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] va, vb, vs;
      logic [15:0] vd;
      {va, vb, vd, vs} = VEC[i];
      wr(3'd0, va);
      wr(3'd1, vb);
      @(negedge clk);
      rd16(0, q); rd16(1, r);
      chk("R2 product", {16'h0, r}, {16'h0, 16'(va) * 16'(vb)});
      chk("R3 quotient kept", {16'h0, q}, {16'h0, exp_q});
      exp_r = 16'(va) * 16'(vb);
      wr(3'd2, vd[7:0]);
      wr(3'd3, vd[15:8]);
      @(negedge clk);
      rd16(0, q); rd16(1, r);
      chk("R4 no start", {31'h0, busy}, 32'h0);
      chk("R4 quotient kept", {16'h0, q}, {16'h0, exp_q});
      chk("R4 result kept", {16'h0, r}, {16'h0, exp_r});
      wr(3'd4, vs);
      if (vs == 8'h00) begin
        chk("R6 no busy", {31'h0, busy}, 32'h0);
        rd16(0, q); rd16(1, r);
        chk("R6 quotient", {16'h0, q}, 32'hFFFF);
        chk("R6 remainder", {16'h0, r}, {16'h0, vd});
        exp_q = 16'hFFFF; exp_r = vd;
      end else begin
        n = 0;
        while (busy && n < 100) begin
          n++;
          chk("R7 ready low in busy", {31'h0, wr_ready}, 32'h0);
          rd16(0, q); rd16(1, r);
          chk("R8 quotient held", {16'h0, q}, {16'h0, exp_q});
          chk("R8 result held", {16'h0, r}, {16'h0, exp_r});
          @(posedge clk); #1;
        end
        chk("R7 busy length", n, DIV_LAT);
        exp_q = vd / 16'(vs);
        exp_r = vd % 16'(vs);
        rd16(0, q); rd16(1, r);
        chk("R5 quotient", {16'h0, q}, {16'h0, exp_q});
        chk("R5 remainder", {16'h0, r}, {16'h0, exp_r});
      end
      // R9 multiplicand survives divide
      wr(3'd1, 8'h03);
      rd16(1, r);
      chk("R9 multiplicand kept", {16'h0, r}, {16'h0, 16'(va) * 16'd3});
      exp_r = 16'(va) * 16'd3;
    end

    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule